// File: doc/BRIEF.md
# I2C Clock Period Timer

This block generates the clock line waveform of an I2C controller from a reference clock. It pulls the line low through an open-drain style output (`scl_drive_low`), counts the low phase, then releases the line. It counts the high phase only after it sees the line high, so a target that holds the line low stretches the clock. Each of the three bus speeds has its own pair of 16-bit high and low counts, and a two-bit speed input chooses the pair. The real phase lengths are the programmed counts plus fixed overheads. Those overheads include the latency of a two-flop synchronizer on the returning line.

Raising `enable` starts a transfer. The line is held released for a START hold time derived from the high count, and then clocking begins. Dropping `enable` ends the run. The low phase in progress (or the next one) completes, the line is released, and after the line is seen high a STOP setup interval, also derived from the high count, runs before the block returns to idle. The counts and the speed choice are captured only while the block is idle and disabled, so a running waveform never changes shape.

Top module: `i2c_scl_timer`

## Requirements
- R1: The `phase` output encodes 0 idle, 1 START hold, 2 low, 3 wait for line high, 4 high, 5 STOP setup. After reset `phase` is 0 and `scl_drive_low` is 0.
- R2: `speed_sel` 2'b00 or 2'b01 selects the standard pair, 2'b10 selects the fast pair, and 2'b11 selects the high-speed pair.
- R3: Every low phase holds `scl_drive_low` at 1 for exactly LO+1 reference clocks, where LO is the selected low count.
- R4: With no stretching, the line stays released between two low phases for exactly HI+8 reference clocks: 3 clocks waiting for the synchronized line, then HI+5 counted clocks in phase 4.
- R5: After `enable` is raised in idle, phase 1 lasts HI+3 clocks with the line released, and then the first low phase begins.
- R6: If the line is held low after the block releases it, phase 3 lasts until two clocks after the line goes high, plus one clock. The released-and-high time that follows is still HI+8 clocks.
- R7: If `enable` is 0 in the last clock of a low phase, the block releases the line, waits for it high, spends HI+3 clocks in phase 5 and then returns to idle. If `enable` drops only after that clock, one more high phase and one more low phase run first.
- R8: Counts and `speed_sel` are captured only in clocks where the block is idle and `enable` is 0. Changes while running, or changes made in the same clock that `enable` is raised, have no effect on the run.
- R9: With parameter `HS_CAPABLE` = 0, a `speed_sel` of 2'b11 uses the fast pair.
- R10: A low count of 0 behaves as a low count of 1, giving a two-clock low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run request; rise starts, fall ends with a STOP interval |
| speed_sel | input | 2 | Speed pair selection |
| std_hi | input | 16 | Standard-mode high count |
| std_lo | input | 16 | Standard-mode low count |
| fast_hi | input | 16 | Fast-mode high count |
| fast_lo | input | 16 | Fast-mode low count |
| hs_hi | input | 16 | High-speed-mode high count |
| hs_lo | input | 16 | High-speed-mode low count |
| scl_in | input | 1 | Sensed clock line level (asynchronous) |
| scl_drive_low | output | 1 | 1 pulls the clock line low, 0 releases it |
| phase | output | 3 | Current phase code |

## Verification
Two pairs of events can land in the same clock. The first is a disable request and the expiry of a low phase. The bench drops `enable` exactly in the last low clock and expects the STOP setup phase to follow the line-high wait. It then drops `enable` one clock later and expects another high phase instead. The second is a count update and the rise of `enable`. The bench changes the standard counts in the very clock that raises `enable`, and judges from the START hold and low lengths that the values captured in the previous idle clock were used.

// File: rtl/i2c_sclgen_pkg.sv
package i2c_sclgen_pkg;

    parameter int CNT_W = 16;
    localparam int CTR_W = CNT_W + 3;

    // Counter preloads; a phase lasts preload+1 clocks
    localparam int START_ADJ = 2;   // START hold = HI + 3
    localparam int HIGH_ADJ  = 4;   // counted high = HI + 5 (plus 3 clocks of line wait)
    localparam int STOP_ADJ  = 2;   // STOP setup = HI + 3
    localparam int LOW_MIN   = 1;   // smallest usable low count

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_START = 3'd1,
        PH_LOW   = 3'd2,
        PH_WAIT  = 3'd3,
        PH_HIGH  = 3'd4,
        PH_STOP  = 3'd5
    } phase_e;

    typedef enum logic [1:0] {
        SPD_STD  = 2'd0,
        SPD_FAST = 2'd1,
        SPD_HIGH = 2'd2
    } speed_e;

    typedef struct packed {
        logic [CNT_W-1:0] hi;
        logic [CNT_W-1:0] lo;
    } pair_t;

    function automatic speed_e decode_speed(input logic [1:0] sel, input logic hs_ok);
        speed_e m;
        case (sel)
            2'b10:   m = SPD_FAST;
            2'b11:   m = hs_ok ? SPD_HIGH : SPD_FAST;
            default: m = SPD_STD;
        endcase
        return m;
    endfunction

    function automatic logic [CNT_W-1:0] floor_low(input logic [CNT_W-1:0] v);
        return (v < CNT_W'(LOW_MIN)) ? CNT_W'(LOW_MIN) : v;
    endfunction

endpackage

// File: rtl/sclgen_sync2.sv
module sclgen_sync2 (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b0;
            q      <= 1'b0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/sclgen_timing_cfg.sv
module sclgen_timing_cfg
    import i2c_sclgen_pkg::*;
#(
    parameter bit HS_CAPABLE = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       load_en,
    input  logic [1:0] speed_sel,
    input  pair_t      std_pair,
    input  pair_t      fast_pair,
    input  pair_t      hs_pair,
    output pair_t      cfg_q
);
    speed_e mode;
    pair_t  pick;

    generate
        if (HS_CAPABLE) begin : g_hs
            assign mode = decode_speed(speed_sel, 1'b1);
        end else begin : g_nohs
            assign mode = decode_speed(speed_sel, 1'b0);
        end
    endgenerate

    always_comb begin
        case (mode)
            SPD_FAST: pick = fast_pair;
            SPD_HIGH: pick = hs_pair;
            default:  pick = std_pair;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '{hi: '0, lo: CNT_W'(LOW_MIN)};
        end else if (load_en) begin
            cfg_q <= '{hi: pick.hi, lo: floor_low(pick.lo)};
        end
    end

    // R9: without high-speed capability the high-speed pair is never chosen
    always_ff @(posedge clk) begin
        if (!rst && !HS_CAPABLE) begin
            p_no_hs_r9: assert (mode != SPD_HIGH);
        end
    end
endmodule

// File: rtl/sclgen_phase_fsm.sv
module sclgen_phase_fsm
    import i2c_sclgen_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   enable,
    input  pair_t  cfg,
    input  logic   scl_hi,
    output phase_e phase_q,
    output logic   drive_low,
    output logic   busy
);
    logic [CTR_W-1:0] cnt;
    logic             stop_q;
    logic [CTR_W-1:0] hi_ext;
    logic [CTR_W-1:0] lo_ext;

    assign hi_ext    = CTR_W'(cfg.hi);
    assign lo_ext    = CTR_W'(cfg.lo);
    assign drive_low = (phase_q == PH_LOW);
    assign busy      = (phase_q != PH_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt     <= '0;
            stop_q  <= 1'b0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (enable) begin
                        phase_q <= PH_START;
                        cnt     <= hi_ext + CTR_W'(START_ADJ);
                    end
                end
                PH_START: begin
                    if (cnt == '0) begin
                        phase_q <= PH_LOW;
                        cnt     <= lo_ext;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_LOW: begin
                    if (cnt == '0) begin
                        phase_q <= PH_WAIT;
                        stop_q  <= !enable;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_WAIT: begin
                    if (scl_hi) begin
                        if (stop_q) begin
                            phase_q <= PH_STOP;
                            cnt     <= hi_ext + CTR_W'(STOP_ADJ);
                        end else begin
                            phase_q <= PH_HIGH;
                            cnt     <= hi_ext + CTR_W'(HIGH_ADJ);
                        end
                    end
                end
                PH_HIGH: begin
                    if (cnt == '0) begin
                        phase_q <= PH_LOW;
                        cnt     <= lo_ext;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_STOP: begin
                    if (cnt == '0) begin
                        phase_q <= PH_IDLE;
                        stop_q  <= 1'b0;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // R3: an expired low phase always hands over to the line-high wait
    p_low_exit_r3: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_LOW && cnt == '0) |=> (phase_q == PH_WAIT));

    // R6: high counting begins only after the synchronized line was high
    p_high_after_line_r6: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_HIGH && $past(phase_q) == PH_WAIT) |-> $past(scl_hi));

    // R5: START hold is entered only from idle with the run request present
    p_start_from_idle_r5: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_START && $past(phase_q) != PH_START)
            |-> ($past(phase_q) == PH_IDLE && $past(enable)));

    // R7: STOP setup ends in idle with the line released
    p_stop_end_r7: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_STOP && cnt == '0) |=> (phase_q == PH_IDLE && !drive_low));
endmodule

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer
    import i2c_sclgen_pkg::*;
#(
    parameter bit HS_CAPABLE = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic [1:0]       speed_sel,
    input  logic [CNT_W-1:0] std_hi,
    input  logic [CNT_W-1:0] std_lo,
    input  logic [CNT_W-1:0] fast_hi,
    input  logic [CNT_W-1:0] fast_lo,
    input  logic [CNT_W-1:0] hs_hi,
    input  logic [CNT_W-1:0] hs_lo,
    input  logic             scl_in,
    output logic             scl_drive_low,
    output logic [2:0]       phase
);
    pair_t  cfg_q;
    logic   scl_hi;
    logic   busy;
    logic   load_en;
    phase_e phase_q;

    assign load_en = !busy && !enable;

    sclgen_sync2 u_sync (
        .clk (clk),
        .rst (rst),
        .d   (scl_in),
        .q   (scl_hi)
    );

    sclgen_timing_cfg #(.HS_CAPABLE(HS_CAPABLE)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .load_en   (load_en),
        .speed_sel (speed_sel),
        .std_pair  ('{hi: std_hi,  lo: std_lo}),
        .fast_pair ('{hi: fast_hi, lo: fast_lo}),
        .hs_pair   ('{hi: hs_hi,   lo: hs_lo}),
        .cfg_q     (cfg_q)
    );

    sclgen_phase_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable),
        .cfg       (cfg_q),
        .scl_hi    (scl_hi),
        .phase_q   (phase_q),
        .drive_low (scl_drive_low),
        .busy      (busy)
    );

    assign phase = phase_q;

    // R8: the captured timing never moves while a run is in progress
    p_cfg_frozen_r8: assert property (@(posedge clk) disable iff (rst)
        busy |-> $stable(cfg_q));
endmodule

// File: tb/i2c_scl_timer_tb.sv
module i2c_scl_timer_tb;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst, en, stretch;
    logic [1:0]  spd;
    logic [15:0] ssh, ssl, fsh, fsl, hsh, hsl;
    logic        drv, ndrv;
    logic [2:0]  ph, nph;
    logic        line, nline;

    assign line  = !(drv | stretch);
    assign nline = !ndrv;

    i2c_scl_timer u_dut (
        .clk(clk), .rst(rst), .enable(en), .speed_sel(spd),
        .std_hi(ssh), .std_lo(ssl), .fast_hi(fsh), .fast_lo(fsl),
        .hs_hi(hsh), .hs_lo(hsl), .scl_in(line),
        .scl_drive_low(drv), .phase(ph)
    );

    i2c_scl_timer #(.HS_CAPABLE(1'b0)) u_dut_nohs (
        .clk(clk), .rst(rst), .enable(en), .speed_sel(spd),
        .std_hi(ssh), .std_lo(ssl), .fast_hi(fsh), .fast_lo(fsl),
        .hs_hi(hsh), .hs_lo(hsl), .scl_in(nline),
        .scl_drive_low(ndrv), .phase(nph)
    );

    // speed, std hi/lo, fast hi/lo, hs hi/lo, expected hi, expected lo, expected lo without hs
    localparam int VEC [4][10] = '{
        '{0, 6, 4, 4, 7, 5, 3, 6, 4, 4},
        '{1, 9, 2, 4, 7, 5, 3, 9, 2, 2},
        '{2, 6, 4, 4, 7, 5, 3, 4, 7, 7},
        '{3, 6, 4, 4, 7, 5, 3, 5, 3, 7}
    };

    int nchk = 0, nfail = 0, cyc = 0;
    int plen [0:7];
    int run = 0, hrun = 0, hlen = 0, nrun = 0, nlen = 0, low_done = 0;
    logic [2:0] prev_ph = 3'd0;

    // Run-length measurement on values of the clock just ending
    always @(posedge clk) begin
        if (ph == prev_ph) run <= run + 1;
        else begin
            plen[prev_ph] <= run;
            run <= 1;
            prev_ph <= ph;
            if (prev_ph == 3'd2) low_done <= low_done + 1;
        end
        if (line) hrun <= hrun + 1;
        else begin
            if (hrun != 0) hlen <= hrun;
            hrun <= 0;
        end
        if (ndrv) nrun <= nrun + 1;
        else begin
            if (nrun != 0) nlen <= nrun;
            nrun <= 0;
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            nchk = nchk + 1;
            nfail = nfail + 1;
            $display("FAIL watchdog actual=%0d expected=idle", cyc);
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        nchk = nchk + 1;
        if (act != exp) begin
            nfail = nfail + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_lows(input int n);
        int base = low_done;
        while (low_done < base + n) @(negedge clk);
    endtask

    task automatic wait_idle();
        while (ph != 3'd0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic wait_phase(input logic [2:0] p);
        while (ph != p) @(negedge clk);
    endtask

    task automatic run_case(input int v [10]);
        @(negedge clk);
        spd = v[0][1:0];
        ssh = 16'(v[1]); ssl = 16'(v[2]);
        fsh = 16'(v[3]); fsl = 16'(v[4]);
        hsh = 16'(v[5]); hsl = 16'(v[6]);
        @(negedge clk);
        en = 1'b1;
        wait_lows(3);
        chk("R5 start hold length", plen[1], v[7] + 3);
        chk("R2 R3 low length of selected pair", plen[2], v[8] + 1);
        chk("R4 released high length", hlen, v[7] + 8);
        chk("R9 low length without high-speed capability", nlen, v[9] + 1);
        en = 1'b0;
        wait_idle();
        chk("R7 stop setup length", plen[5], v[7] + 3);
        chk("R7 line released in idle", int'(drv), 0);
    endtask

    initial begin
        rst = 1'b1; en = 1'b1; stretch = 1'b0; spd = 2'b00;
        ssh = 16'd6; ssl = 16'd4; fsh = 16'd4; fsl = 16'd7; hsh = 16'd5; hsl = 16'd3;
        for (int i = 0; i < 8; i++) plen[i] = 0;
        repeat (3) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset phase", int'(ph), 0);
        chk("R1 reset drive", int'(drv), 0);

        for (int i = 0; i < 4; i++) run_case(VEC[i]);

        // R8: counts changed while running are ignored
        @(negedge clk);
        spd = 2'b00; ssh = 16'd6; ssl = 16'd4;
        @(negedge clk);
        en = 1'b1;
        wait_lows(1);
        ssh = 16'd10; ssl = 16'd10;
        wait_lows(2);
        chk("R8 low unchanged while running", plen[2], 5);
        chk("R8 high unchanged while running", hlen, 14);
        en = 1'b0;
        wait_idle();

        // R8: counts changed in the clock enable rises are ignored
        @(negedge clk);
        ssh = 16'd3; ssl = 16'd3; en = 1'b1;
        wait_lows(1);
        chk("R8 start hold uses previous idle counts", plen[1], 13);
        chk("R8 low uses previous idle counts", plen[2], 11);
        en = 1'b0;
        wait_idle();

        // R10: zero low count
        @(negedge clk);
        ssh = 16'd2; ssl = 16'd0;
        @(negedge clk);
        en = 1'b1;
        wait_lows(2);
        chk("R10 zero low count gives two clocks", plen[2], 2);
        chk("R10 high after short low", hlen, 10);
        en = 1'b0;
        wait_idle();

        // R6: target stretches the clock
        @(negedge clk);
        ssh = 16'd4; ssl = 16'd5;
        @(negedge clk);
        en = 1'b1;
        wait_phase(3'd2);
        stretch = 1'b1;
        wait_phase(3'd3);
        repeat (7) @(negedge clk);
        stretch = 1'b0;
        wait_lows(1);
        chk("R6 wait phase length under stretch", plen[3], 10);
        chk("R6 released high after stretch", hlen, 12);
        en = 1'b0;
        wait_idle();

        // R7: disable in the last low clock
        @(negedge clk);
        ssh = 16'd3; ssl = 16'd4;
        @(negedge clk);
        en = 1'b1;
        wait_phase(3'd2);
        repeat (4) @(negedge clk);
        en = 1'b0;
        while (ph == 3'd2) @(negedge clk);
        while (ph == 3'd3) @(negedge clk);
        chk("R7 disable at low expiry goes to stop", int'(ph), 5);
        chk("R7 line released during stop", int'(drv), 0);
        wait_idle();

        // R7: disable one clock after low expiry
        @(negedge clk);
        en = 1'b1;
        wait_phase(3'd2);
        repeat (5) @(negedge clk);
        en = 1'b0;
        while (ph == 3'd3) @(negedge clk);
        chk("R7 late disable runs another high", int'(ph), 4);
        wait_idle();
        chk("R7 returns to idle", int'(ph), 0);

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule